// File: doc/BRIEF.md
# Fully Associative Page Translation Cache

This block keeps a small set of recent page translations for a 32-bit linear address space with 4 KB pages. A lookup splits the incoming address into a 20-bit page number (bits 31:12) and a 12-bit page offset (bits 11:0). It compares the page number against the tag of every entry in the same cycle. When a valid entry matches, the block returns the physical address. That address is the stored 20-bit frame number placed above the untouched offset. The entry's four attribute bits come back with it: modified, accessed, write-allowed and user-level.

Each entry is found by its stored page tag, never by position. A single write port either fills an entry or invalidates every entry whose tag equals a given page number. A fill goes to the lowest-numbered empty entry. When no entry is empty, the fill replaces the entry named by a round-robin pointer. A flush input empties the whole structure in one clock. Page-table walking, fault signalling and other replacement policies belong to the surrounding logic.

Top module: `xlat_cache`

## Requirements
- R1: After a cycle with `rst` high, every entry is empty, so any lookup reports a miss.
- R2: A lookup whose page number matches a valid entry drives `lk_hit` high and `lk_paddr` = {stored frame, `lk_vaddr[11:0]`} in the same cycle (for example, page 00004h mapped to frame 10000h turns 00004123h into 10000123h; an offset of FFFh passes unchanged).
- R3: A lookup with no valid match drives `lk_hit`, `lk_paddr` and all four attribute outputs to zero.
- R4: On a hit, `lk_dirty`, `lk_refd`, `lk_wr_ok` and `lk_user` equal the bits written with that entry's fill.
- R5: A fill (`wr_en`=1, `wr_inv`=0) takes effect at the next rising clock edge. A lookup of the same page in the cycle before that edge still misses.
- R6: A fill goes to the lowest-numbered empty entry and leaves the round-robin pointer unchanged. A page that is already valid is not evicted while an empty entry exists.
- R7: When every entry is valid, a fill replaces the entry at the round-robin pointer, and the pointer then advances by one. It wraps from the last entry to entry 0 and starts at entry 0 after reset.
- R8: An invalidate (`wr_en`=1, `wr_inv`=1) empties every entry whose tag equals `wr_vpn` and leaves all other entries unchanged.
- R9: `flush` empties every entry at the next edge. A write presented in the same cycle is ignored.
- R10: If several valid entries match the same page, the lowest-numbered one supplies the frame and attributes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| lk_vaddr | input | 32 | Linear address to translate |
| lk_hit | output | 1 | A valid entry matched |
| lk_paddr | output | 32 | Physical address on a hit, zero on a miss |
| lk_dirty | output | 1 | Modified bit of the matching entry |
| lk_refd | output | 1 | Accessed bit of the matching entry |
| lk_wr_ok | output | 1 | Write-allowed bit of the matching entry |
| lk_user | output | 1 | User-level bit of the matching entry |
| wr_en | input | 1 | Write request |
| wr_inv | input | 1 | 1 = invalidate by page, 0 = fill |
| wr_vpn | input | 20 | Page number to fill or invalidate |
| wr_pfn | input | 20 | Frame number for a fill |
| wr_dirty | input | 1 | Modified bit for a fill |
| wr_refd | input | 1 | Accessed bit for a fill |
| wr_wr_ok | input | 1 | Write-allowed bit for a fill |
| wr_user | input | 1 | User-level bit for a fill |
| flush | input | 1 | Empty all entries |

## Verification
The embedded properties check these points on every cycle:
- The offset passes through on a hit, and a miss leaves the outputs quiet.
- A flush or reset empties the valid vector.
- An invalidated tag is gone one edge later.
- The fill target is at most one-hot.
- The round-robin pointer steps only on a fill into a full structure.
- A hit always comes from the lowest matching entry.

Only the bench's scenarios show where a fill lands. They do this by evicting pages and watching which ones disappear. The same scenarios show that an empty slot is taken before round-robin replacement, that a flush ignores a write in the same cycle, and that a same-cycle lookup does not see a pending fill.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int VA_W  = 32;
  localparam int OFS_W = 12;
  localparam int VPN_W = VA_W - OFS_W;
  localparam int PFN_W = 20;
  localparam int PA_W  = PFN_W + OFS_W;

  typedef struct packed {
    logic dirty;
    logic refd;
    logic wr_ok;
    logic user;
  } xlat_attr_t;

  typedef struct packed {
    logic [VPN_W-1:0] vpn;
    logic [PFN_W-1:0] pfn;
    xlat_attr_t       attr;
  } xlat_ent_t;
endpackage

// File: rtl/xlat_store.sv
module xlat_store
  import xlat_pkg::*;
#(
  parameter int N = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             fill_en,
  input  logic [N-1:0]     fill_sel,
  input  xlat_ent_t        fill_ent,
  input  logic             inv_en,
  input  logic [VPN_W-1:0] inv_vpn,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic [N-1:0]     valid_vec,
  output logic [N-1:0]     match_vec,
  output xlat_ent_t        ents [N]
);
  logic [N-1:0] inv_hit;

  for (genvar g = 0; g < N; g++) begin : g_ent
    assign inv_hit[g]   = valid_vec[g] && (ents[g].vpn == inv_vpn);
    assign match_vec[g] = valid_vec[g] && (ents[g].vpn == lk_vpn);

    always_ff @(posedge clk) begin
      if (rst || flush) begin
        valid_vec[g] <= 1'b0;
      end else if (fill_en && fill_sel[g]) begin
        valid_vec[g] <= 1'b1;
      end else if (inv_en && inv_hit[g]) begin
        valid_vec[g] <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (!flush && fill_en && fill_sel[g]) begin
        ents[g] <= fill_ent;
      end
    end
  end

  AST_RESET_EMPTY: assert property (@(posedge clk) rst |=> (valid_vec == '0)); // R1
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
    flush |=> (valid_vec == '0)); // R9
  AST_INV_GONE: assert property (@(posedge clk) disable iff (rst)
    (inv_en && !flush) |=> ((valid_vec & $past(inv_hit)) == '0)); // R8
endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         flush,
  input  logic         fill_req,
  input  logic [N-1:0] valid_vec,
  output logic [N-1:0] fill_sel
);
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

  logic [IDX_W-1:0] rr_ptr;
  logic [IDX_W-1:0] free_idx;
  logic             full;
  logic             rr_use;

  always_comb begin
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid_vec[i]) free_idx = IDX_W'(i);
    end
  end

  assign full   = &valid_vec;
  assign rr_use = fill_req && full && !flush;

  always_comb begin
    fill_sel = '0;
    if (fill_req) begin
      if (full) fill_sel[rr_ptr] = 1'b1;
      else      fill_sel[free_idx] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rr_ptr <= '0;
    end else if (rr_use) begin
      rr_ptr <= (rr_ptr == IDX_W'(N - 1)) ? '0 : rr_ptr + 1'b1;
    end
  end

  AST_FILL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(fill_sel)); // R6
  AST_RR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (fill_req && !full) |=> $stable(rr_ptr)); // R6
  AST_RR_STEP: assert property (@(posedge clk) disable iff (rst)
    rr_use |=> (rr_ptr == (($past(rr_ptr) == IDX_W'(N - 1)) ? '0 : $past(rr_ptr) + 1'b1))); // R7
endmodule

// File: rtl/xlat_pick.sv
module xlat_pick
  import xlat_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] match_vec,
  input  xlat_ent_t    ents [N],
  output logic         hit,
  output logic [PFN_W-1:0] pfn,
  output xlat_attr_t   attr
);
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

  logic [IDX_W-1:0] sel_idx;

  always_comb begin
    sel_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match_vec[i]) sel_idx = IDX_W'(i);
    end
  end

  assign hit  = |match_vec;
  assign pfn  = hit ? ents[sel_idx].pfn  : '0;
  assign attr = hit ? ents[sel_idx].attr : '0;

  AST_PICK_LOWEST: assert property (@(posedge clk) disable iff (rst)
    hit |-> (match_vec[sel_idx] && ((match_vec & ((N'(1) << sel_idx) - N'(1))) == '0))); // R10
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [31:0] lk_vaddr,
  output logic        lk_hit,
  output logic [31:0] lk_paddr,
  output logic        lk_dirty,
  output logic        lk_refd,
  output logic        lk_wr_ok,
  output logic        lk_user,
  input  logic        wr_en,
  input  logic        wr_inv,
  input  logic [19:0] wr_vpn,
  input  logic [19:0] wr_pfn,
  input  logic        wr_dirty,
  input  logic        wr_refd,
  input  logic        wr_wr_ok,
  input  logic        wr_user,
  input  logic        flush
);
  logic [ENTRIES-1:0] valid_vec;
  logic [ENTRIES-1:0] match_vec;
  logic [ENTRIES-1:0] fill_sel;
  xlat_ent_t          ents [ENTRIES];
  xlat_ent_t          fill_ent;
  logic               fill_req;
  logic               inv_req;
  logic [PFN_W-1:0]   hit_pfn;
  xlat_attr_t         hit_attr;

  assign fill_req = wr_en && !wr_inv;
  assign inv_req  = wr_en && wr_inv;

  assign fill_ent.vpn  = wr_vpn;
  assign fill_ent.pfn  = wr_pfn;
  assign fill_ent.attr = '{dirty: wr_dirty, refd: wr_refd, wr_ok: wr_wr_ok, user: wr_user};

  xlat_victim #(.N(ENTRIES)) u_victim (
    .clk(clk), .rst(rst), .flush(flush), .fill_req(fill_req),
    .valid_vec(valid_vec), .fill_sel(fill_sel)
  );

  xlat_store #(.N(ENTRIES)) u_store (
    .clk(clk), .rst(rst), .flush(flush),
    .fill_en(fill_req), .fill_sel(fill_sel), .fill_ent(fill_ent),
    .inv_en(inv_req), .inv_vpn(wr_vpn),
    .lk_vpn(lk_vaddr[VA_W-1:OFS_W]),
    .valid_vec(valid_vec), .match_vec(match_vec), .ents(ents)
  );

  xlat_pick #(.N(ENTRIES)) u_pick (
    .clk(clk), .rst(rst), .match_vec(match_vec), .ents(ents),
    .hit(lk_hit), .pfn(hit_pfn), .attr(hit_attr)
  );

  assign lk_paddr = lk_hit ? {hit_pfn, lk_vaddr[OFS_W-1:0]} : '0;
  assign lk_dirty = hit_attr.dirty;
  assign lk_refd  = hit_attr.refd;
  assign lk_wr_ok = hit_attr.wr_ok;
  assign lk_user  = hit_attr.user;

  AST_OFS_PASS: assert property (@(posedge clk) disable iff (rst)
    lk_hit |-> (lk_paddr[11:0] == lk_vaddr[11:0])); // R2
  AST_MISS_QUIET: assert property (@(posedge clk) disable iff (rst)
    !lk_hit |-> (lk_paddr == '0 && !lk_dirty && !lk_refd && !lk_wr_ok && !lk_user)); // R3
  AST_HIT_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    lk_hit |-> (valid_vec != '0)); // R2
endmodule

// File: tb/test_xlat_cache.sv
`timescale 1ns/1ps
module test_xlat_cache;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] lk_vaddr = '0;
  logic        lk_hit, lk_dirty, lk_refd, lk_wr_ok, lk_user;
  logic [31:0] lk_paddr;
  logic        wr_en = 1'b0, wr_inv = 1'b0, flush = 1'b0;
  logic [19:0] wr_vpn = '0, wr_pfn = '0;
  logic        wr_dirty = 1'b0, wr_refd = 1'b0, wr_wr_ok = 1'b0, wr_user = 1'b0;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  xlat_cache i_xlat_cache (
    .clk(clk), .rst(rst), .lk_vaddr(lk_vaddr), .lk_hit(lk_hit), .lk_paddr(lk_paddr),
    .lk_dirty(lk_dirty), .lk_refd(lk_refd), .lk_wr_ok(lk_wr_ok), .lk_user(lk_user),
    .wr_en(wr_en), .wr_inv(wr_inv), .wr_vpn(wr_vpn), .wr_pfn(wr_pfn),
    .wr_dirty(wr_dirty), .wr_refd(wr_refd), .wr_wr_ok(wr_wr_ok), .wr_user(wr_user),
    .flush(flush)
  );

  // vector: {vaddr[32], hit[1], paddr[32], attr{dirty,refd,wr_ok,user}[4]}
  localparam int NV = 7;
  localparam logic [68:0] VECS [NV] = '{
    {32'h00004123, 1'b1, 32'h10000123, 4'b1010},
    {32'h00010FFF, 1'b1, 32'h12345FFF, 4'b0101},
    {32'h1F005000, 1'b0, 32'h00000000, 4'b0000},
    {32'h00004000, 1'b1, 32'h10000000, 4'b1010},
    {32'h00005123, 1'b0, 32'h00000000, 4'b0000},
    {32'hABCDE7A5, 1'b1, 32'h3F0007A5, 4'b1111},
    {32'h00010000, 1'b1, 32'h12345000, 4'b0101}
  };

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic look(input logic [31:0] va, input logic eh, input logic [31:0] ep,
                      input logic [3:0] ea, input string req);
    logic [3:0] aa;
    @(negedge clk);
    lk_vaddr = va;
    #1;
    aa = {lk_dirty, lk_refd, lk_wr_ok, lk_user};
    n_chk++;
    if (lk_hit !== eh || lk_paddr !== ep || aa !== ea) begin
      n_fail++;
      $display("FAIL %s va=%h: hit=%b paddr=%h attr=%b expected hit=%b paddr=%h attr=%b",
               req, va, lk_hit, lk_paddr, aa, eh, ep, ea);
    end
  endtask

  task automatic wr(input logic inv, input logic [19:0] vpn, input logic [19:0] pfn,
                    input logic [3:0] at, input logic fl);
    @(negedge clk);
    wr_en = 1'b1; wr_inv = inv; wr_vpn = vpn; wr_pfn = pfn;
    {wr_dirty, wr_refd, wr_wr_ok, wr_user} = at; flush = fl;
    @(posedge clk);
    #1;
    wr_en = 1'b0; flush = 1'b0;
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush = 1'b1;
    @(posedge clk);
    #1;
    flush = 1'b0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog: cycles=%0d expected completion", cycles);
        summary();
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R1: empty after reset
    look(32'h00000000, 1'b0, 32'h0, 4'h0, "R1");
    look(32'h00004123, 1'b0, 32'h0, 4'h0, "R1");

    // table walk: R2 R3 R4
    wr(1'b0, 20'h00004, 20'h10000, 4'b1010, 1'b0);
    wr(1'b0, 20'h00010, 20'h12345, 4'b0101, 1'b0);
    wr(1'b0, 20'hABCDE, 20'h3F000, 4'b1111, 1'b0);
    for (int k = 0; k < NV; k++) begin
      look(VECS[k][68:37], VECS[k][36], VECS[k][35:4], VECS[k][3:0],
           VECS[k][36] ? "R2/R4 table" : "R3 table");
    end

    // R5: fill not visible before its edge
    @(negedge clk);
    wr_en = 1'b1; wr_inv = 1'b0; wr_vpn = 20'h0C0DE; wr_pfn = 20'h55555;
    {wr_dirty, wr_refd, wr_wr_ok, wr_user} = 4'b0011;
    lk_vaddr = 32'h0C0DE001;
    #1;
    n_chk++;
    if (lk_hit !== 1'b0) begin
      n_fail++;
      $display("FAIL R5 same-cycle: hit=%b expected 0", lk_hit);
    end
    @(posedge clk);
    #1 wr_en = 1'b0;
    look(32'h0C0DE001, 1'b1, 32'h55555001, 4'b0011, "R5");

    // R7: fill 8 pages, then round-robin eviction from entry 0
    do_flush();
    look(32'h00004123, 1'b0, 32'h0, 4'h0, "R9 flush");
    for (int k = 0; k < 8; k++) wr(1'b0, 20'h00100 + 20'(k), 20'h00200 + 20'(k), 4'b0000, 1'b0);
    wr(1'b0, 20'h00900, 20'h00990, 4'b0100, 1'b0);
    look(32'h00100000, 1'b0, 32'h0, 4'h0, "R7 evict entry0");
    look(32'h00900ABC, 1'b1, 32'h00990ABC, 4'b0100, "R7");
    look(32'h00101010, 1'b1, 32'h00201010, 4'b0000, "R7 entry1 kept");
    wr(1'b0, 20'h00901, 20'h00991, 4'b0000, 1'b0);
    look(32'h00101010, 1'b0, 32'h0, 4'h0, "R7 evict entry1");

    // R8 and R6: invalidate two, refill goes to empty slots, next RR victim entry2
    wr(1'b1, 20'h00105, 20'h0, 4'h0, 1'b0);
    look(32'h00105000, 1'b0, 32'h0, 4'h0, "R8");
    look(32'h00104000, 1'b1, 32'h00204000, 4'b0000, "R8 neighbour kept");
    wr(1'b1, 20'h00103, 20'h0, 4'h0, 1'b0);
    wr(1'b0, 20'h00A00, 20'h00AA0, 4'b1000, 1'b0);
    wr(1'b0, 20'h00A01, 20'h00AA1, 4'b0010, 1'b0);
    look(32'h00102000, 1'b1, 32'h00202000, 4'b0000, "R6 no eviction");
    wr(1'b0, 20'h00A02, 20'h00AA2, 4'b0001, 1'b0);
    look(32'h00102000, 1'b0, 32'h0, 4'h0, "R6/R7 pointer held at entry2");
    look(32'h00A00FFF, 1'b1, 32'h00AA0FFF, 4'b1000, "R6");
    look(32'h00A01000, 1'b1, 32'h00AA1000, 4'b0010, "R6");
    look(32'h00A02123, 1'b1, 32'h00AA2123, 4'b0001, "R6");

    // R10: duplicate tags, lowest entry wins; R8 clears both
    do_flush();
    wr(1'b0, 20'h77777, 20'h11111, 4'b1100, 1'b0);
    wr(1'b0, 20'h77777, 20'h22222, 4'b0011, 1'b0);
    wr(1'b0, 20'h00042, 20'h00043, 4'b0000, 1'b0);
    look(32'h77777345, 1'b1, 32'h11111345, 4'b1100, "R10");
    wr(1'b1, 20'h77777, 20'h0, 4'h0, 1'b0);
    look(32'h77777345, 1'b0, 32'h0, 4'h0, "R8 all matches");
    look(32'h00042001, 1'b1, 32'h00043001, 4'b0000, "R8 other kept");

    // R9: flush wins over simultaneous fill
    wr(1'b0, 20'h0BEEF, 20'h0CAFE, 4'b1111, 1'b1);
    look(32'h0BEEF000, 1'b0, 32'h0, 4'h0, "R9 write ignored");
    look(32'h00042001, 1'b0, 32'h0, 4'h0, "R9");

    // R1: reset mid-run empties contents
    wr(1'b0, 20'h00300, 20'h00301, 4'b0000, 1'b0);
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    look(32'h00300000, 1'b0, 32'h0, 4'h0, "R1 mid-run");

    summary();
  end
endmodule